// File: doc/BRIEF.md
# Masked Peripheral Register Bank

This block is a bank of 16-bit control and status registers in the peripheral space of a handheld-console-style system. A simple bus drives it. The bus carries a 10-bit byte address, 16-bit write data, a size select that picks a halfword or byte access, a write strobe and a read strobe. The bank answers every read with a registered halfword and an error flag, one cycle after the strobe.

The video, audio, DMA and timer engines sit outside the bank. The bank holds only the software view of their controls. Each register keeps just the bits its write mask allows. Some bits are live status driven by the engines. Interrupt flags clear when software writes a one to them. Write-only registers answer reads with a designated bad value. Channel and mix audio registers read as zero while the audio master enable is off. A byte written to the halt-control address raises a one-cycle halt or stop request and is not stored.

Top module: `periph_regbank`

## Requirements
- R1: After reset, the registers read as follows: display control (0x000) reads 0x0080, key register (0x130) reads 0x03FF, sound bias (0x088) reads 0x0200, and the interrupt-flag register (0x202) reads 0x0000. In `wo_view`, halfword slot i sits at bits [16*i+15:16*i]. Slots 4 and 7 (affine PA at 0x018 and PD at 0x01E) hold 0x0100, and every other slot holds 0.
- R2: Writes are masked per register. The timer high controls at 0x102, 0x106, 0x10A and 0x10E keep 0x00C7. Channel-1 sweep (0x060) keeps 0x007F. Channel-3 low (0x070) keeps 0x00E0 and channel-3 high (0x072) keeps 0xE03F. Master volume (0x080) keeps 0xFF77, mix control (0x082) keeps 0x770F and the interrupt master enable (0x208) keeps 0x0001.
- R3: Display status (0x004) stores only bits 15..3 of a write. Its bits 2..0 always read as the `vid_stat` input.
- R4: Audio master control (0x084) stores only bit 7 of a write. Its bits 3..0 read as the `snd_act` input, and `snd_on` follows the stored bit 7.
- R5: While bit 7 of 0x084 is 0, reads of 0x060, 0x070, 0x072, 0x080 and 0x082 return 0 with no error. The stored values are kept, and sound bias and 0x084 still read normally.
- R6: A halfword write to 0x202 clears each flag bit where the write data has a 1 and leaves the other bits unchanged. Each cycle, the flag bits are also set wherever `irq_raise` is 1.
- R7: A byte write (`bsel`=1) takes its byte from wdata[7:0] and places it in the lane chosen by addr[0] (1 selects the high byte). It merges that byte with the other stored byte and then acts as a halfword write at the even address. This also applies to 0x202, where the merged halfword is the clear mask.
- R8: Reads from the write-only ranges return BAD_VALUE with `rerr`=1. These ranges are the offset and affine parameters 0x010..0x01F and the DMA address and count registers 0x0B0..0x0B9. Writes to 0x010..0x01F update `wo_view`.
- R9: Reads from unmapped addresses return BAD_VALUE with `rerr`=1.
- R10: A byte write to 0x301 pulses `halt_req` for one cycle when wdata[7] is 0, and pulses `stop_req` for one cycle when wdata[7] is 1. A halfword write to that location requests neither.
- R11: `rdata` and `rerr` update in the cycle after `rd`. They hold their value until the next read, and a readable register returns `rerr`=0.
- R12: When a clear-by-write to 0x202 and an `irq_raise` bit hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 10 | Byte address |
| wdata | input | 16 | Write data (byte writes use bits 7..0) |
| bsel | input | 1 | 1 = byte access, 0 = halfword access |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| vid_stat | input | 3 | Live display status bits |
| snd_act | input | 4 | Live audio channel activity bits |
| irq_raise | input | 16 | Interrupt flag set requests |
| rdata | output | 16 | Registered read data |
| rerr | output | 1 | Registered read error flag |
| halt_req | output | 1 | One-cycle halt request |
| stop_req | output | 1 | One-cycle stop request |
| disp_ctrl | output | 16 | Display control register view |
| snd_on | output | 1 | Audio master enable |
| wo_view | output | 128 | Write-only video parameter view |

## Verification
The bench builds the bank with BAD_VALUE set to 0xA5C3, so the bad-read value cannot be mistaken for a stored register. It keeps TMR_N at 4, which puts both the first and the last timer control inside the tested map. Live status inputs are held at patterns that differ from anything written, so the read-only status bits can be seen separately from the stored bits. Interrupt raise and clear collide on purpose, and a byte write to the flag register is used to expose how the merge widens its clear mask.

// File: rtl/periph_regbank.sv
module periph_regbank #(
  parameter logic [15:0] BAD_VALUE = 16'hBAD0,
  parameter int          TMR_N     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [9:0]   addr,
  input  logic [15:0]  wdata,
  input  logic         bsel,
  input  logic         wr,
  input  logic         rd,
  input  logic [2:0]   vid_stat,
  input  logic [3:0]   snd_act,
  input  logic [15:0]  irq_raise,
  output logic [15:0]  rdata,
  output logic         rerr,
  output logic         halt_req,
  output logic         stop_req,
  output logic [15:0]  disp_ctrl,
  output logic         snd_on,
  output logic [127:0] wo_view
);

  localparam logic [9:0] A_DCTL  = 10'h000;
  localparam logic [9:0] A_DSTAT = 10'h004;
  localparam logic [9:0] A_CH1SW = 10'h060;
  localparam logic [9:0] A_CH3LO = 10'h070;
  localparam logic [9:0] A_CH3HI = 10'h072;
  localparam logic [9:0] A_MVOL  = 10'h080;
  localparam logic [9:0] A_MIX   = 10'h082;
  localparam logic [9:0] A_SCTL  = 10'h084;
  localparam logic [9:0] A_BIAS  = 10'h088;
  localparam logic [9:0] A_DMA_F = 10'h0B0;
  localparam logic [9:0] A_DMA_L = 10'h0B8;
  localparam int         A_TMR0  = 'h102;
  localparam logic [9:0] A_KEY   = 10'h130;
  localparam logic [9:0] A_IE    = 10'h200;
  localparam logic [9:0] A_IF    = 10'h202;
  localparam logic [9:0] A_IME   = 10'h208;
  localparam logic [9:0] A_HALT  = 10'h301;
  localparam int         WO_N    = 8;

  logic [15:0] dctl, ch1sw, ch3lo, ch3hi, mvol, mix, bias, keyr, ie, ifl;
  logic [12:0] dst;
  logic        sen, ime;
  logic [15:0] wo  [WO_N];
  logic [15:0] tmh [TMR_N];

  logic [9:0]  wa;
  logic [15:0] raw, wv;
  logic        err, gate, we, wo_hit, hlt_wr;

  assign wa        = {addr[9:1], 1'b0};
  assign wo_hit    = (wa[9:4] == 6'h01);
  assign hlt_wr    = wr && bsel && (addr == A_HALT);
  assign we        = wr && !hlt_wr;
  assign disp_ctrl = dctl;
  assign snd_on    = sen;

  for (genvar g = 0; g < WO_N; g++) begin : g_view
    assign wo_view[16*g +: 16] = wo[g];
  end

  always_comb begin
    raw  = 16'h0000;
    err  = 1'b0;
    gate = 1'b0;
    case (wa)
      A_DCTL:  raw = dctl;
      A_DSTAT: raw = {dst, vid_stat};
      A_CH1SW: begin raw = ch1sw; gate = 1'b1; end
      A_CH3LO: begin raw = ch3lo; gate = 1'b1; end
      A_CH3HI: begin raw = ch3hi; gate = 1'b1; end
      A_MVOL:  begin raw = mvol;  gate = 1'b1; end
      A_MIX:   begin raw = mix;   gate = 1'b1; end
      A_SCTL:  raw = {8'h00, sen, 3'b000, snd_act};
      A_BIAS:  raw = bias;
      A_KEY:   raw = keyr;
      A_IE:    raw = ie;
      A_IF:    raw = ifl;
      A_IME:   raw = {15'h0000, ime};
      default: err = 1'b1;
    endcase
    for (int i = 0; i < TMR_N; i++) begin
      if (wa == 10'(A_TMR0 + 4 * i)) begin
        raw = tmh[i];
        err = 1'b0;
      end
    end
    if (wo_hit) begin
      raw = wo[wa[3:1]];
      err = 1'b1;
    end
    if (wa >= A_DMA_F && wa <= A_DMA_L) err = 1'b1;
  end

  assign wv = !bsel ? wdata :
              addr[0] ? {wdata[7:0], raw[7:0]} : {raw[15:8], wdata[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dctl  <= 16'h0080;
      dst   <= '0;
      ch1sw <= '0;
      ch3lo <= '0;
      ch3hi <= '0;
      mvol  <= '0;
      mix   <= '0;
      sen   <= 1'b0;
      bias  <= 16'h0200;
      keyr  <= 16'h03FF;
      ie    <= '0;
      ifl   <= '0;
      ime   <= 1'b0;
      for (int i = 0; i < WO_N; i++)
        wo[i] <= (i == 4 || i == 7) ? 16'h0100 : 16'h0000;
      for (int i = 0; i < TMR_N; i++) tmh[i] <= '0;
      rdata    <= '0;
      rerr     <= 1'b0;
      halt_req <= 1'b0;
      stop_req <= 1'b0;
    end else begin
      halt_req <= hlt_wr && !wdata[7];
      stop_req <= hlt_wr && wdata[7];
      ifl <= ((we && wa == A_IF) ? (ifl & ~wv) : ifl) | irq_raise;
      if (we) begin
        case (wa)
          A_DCTL:  dctl  <= wv;
          A_DSTAT: dst   <= wv[15:3];
          A_CH1SW: ch1sw <= wv & 16'h007F;
          A_CH3LO: ch3lo <= wv & 16'h00E0;
          A_CH3HI: ch3hi <= wv & 16'hE03F;
          A_MVOL:  mvol  <= wv & 16'hFF77;
          A_MIX:   mix   <= wv & 16'h770F;
          A_SCTL:  sen   <= wv[7];
          A_BIAS:  bias  <= wv;
          A_KEY:   keyr  <= wv & 16'h03FF;
          A_IE:    ie    <= wv;
          A_IME:   ime   <= wv[0];
          default: ;
        endcase
        if (wo_hit) wo[wa[3:1]] <= wv;
        for (int i = 0; i < TMR_N; i++)
          if (wa == 10'(A_TMR0 + 4 * i)) tmh[i] <= wv & 16'h00C7;
      end
      if (rd) begin
        rerr  <= err;
        rdata <= err ? BAD_VALUE : (gate && !sen) ? 16'h0000 : raw;
      end
    end
  end

endmodule

// File: rtl/periph_regbank_chk.sv
module periph_regbank_chk #(
  parameter logic [15:0] BAD_VALUE = 16'hBAD0
) (
  input logic        clk,
  input logic        rst_n,
  input logic [9:0]  addr,
  input logic [15:0] wdata,
  input logic        bsel,
  input logic        wr,
  input logic        rd,
  input logic [15:0] irq_raise,
  input logic [15:0] rdata,
  input logic        rerr,
  input logic        halt_req,
  input logic        stop_req,
  input logic        snd_on,
  input logic [15:0] ifl
);

  assert_bad_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rerr |-> rdata == BAD_VALUE);

  assert_one_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_req && stop_req));

  assert_halt_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(wr && bsel && addr == 10'h301 && !wdata[7]));

  assert_read_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata) && $stable(rerr));

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !bsel && addr == 10'h202 && irq_raise == 16'h0000)
      |=> ifl == ($past(ifl) & ~$past(wdata)));

  assert_raise_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_raise != 16'h0000) |=> ((ifl & $past(irq_raise)) == $past(irq_raise)));

  assert_audio_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == 10'h082 && !snd_on && !wr) |=> rdata == 16'h0000 && !rerr);

endmodule

bind periph_regbank periph_regbank_chk #(.BAD_VALUE(BAD_VALUE)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .bsel(bsel),
  .wr(wr), .rd(rd), .irq_raise(irq_raise), .rdata(rdata), .rerr(rerr),
  .halt_req(halt_req), .stop_req(stop_req), .snd_on(snd_on), .ifl(ifl)
);

// File: tb/periph_regbank_test.sv
`timescale 1ns/1ps
module periph_regbank_test;
  localparam logic [15:0] BAD = 16'hA5C3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [9:0]   addr = '0;
  logic [15:0]  wdata = '0;
  logic         bsel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [2:0]   vid_stat = 3'b101;
  logic [3:0]   snd_act = 4'hA;
  logic [15:0]  irq_raise = '0;
  logic [15:0]  rdata, disp_ctrl;
  logic         rerr, halt_req, stop_req, snd_on;
  logic [127:0] wo_view;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  periph_regbank #(.BAD_VALUE(BAD), .TMR_N(4)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .bsel(bsel),
    .wr(wr), .rd(rd), .vid_stat(vid_stat), .snd_act(snd_act),
    .irq_raise(irq_raise), .rdata(rdata), .rerr(rerr), .halt_req(halt_req),
    .stop_req(stop_req), .disp_ctrl(disp_ctrl), .snd_on(snd_on), .wo_view(wo_view)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_h(input logic [9:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; bsel = 1'b0; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic wr_b(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = {8'h00, d}; bsel = 1'b1; wr = 1'b1;
    @(negedge clk); wr = 1'b0; bsel = 1'b0;
  endtask

  task automatic rd_h(input logic [9:0] a, output logic [15:0] d, output logic e);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata; e = rerr;
  endtask

  task automatic expect_rd(input string req, input logic [9:0] a, input logic [15:0] exp,
                           input logic exp_err);
    logic [15:0] d; logic e;
    rd_h(a, d, e);
    chk(req, d, exp);
    chk({req, " err"}, {15'h0, e}, {15'h0, exp_err});
  endtask

  task automatic t_reset;
    expect_rd("R1 dctl", 10'h000, 16'h0080, 1'b0);
    expect_rd("R1 key", 10'h130, 16'h03FF, 1'b0);
    expect_rd("R1 bias", 10'h088, 16'h0200, 1'b0);
    expect_rd("R1 if", 10'h202, 16'h0000, 1'b0);
    chk("R1 pa", wo_view[79:64], 16'h0100);
    chk("R1 pd", wo_view[127:112], 16'h0100);
    chk("R1 pb", wo_view[95:80], 16'h0000);
    chk("R1 halt", {14'h0, halt_req, stop_req}, 16'h0000);
  endtask

  task automatic t_masks;
    wr_h(10'h084, 16'h0080);
    wr_h(10'h102, 16'hFFFF); expect_rd("R2 tmr0", 10'h102, 16'h00C7, 1'b0);
    wr_h(10'h10E, 16'h1234); expect_rd("R2 tmr3", 10'h10E, 16'h0004, 1'b0);
    wr_h(10'h060, 16'hFFFF); expect_rd("R2 ch1sw", 10'h060, 16'h007F, 1'b0);
    wr_h(10'h070, 16'hFFFF); expect_rd("R2 ch3lo", 10'h070, 16'h00E0, 1'b0);
    wr_h(10'h072, 16'hFFFF); expect_rd("R2 ch3hi", 10'h072, 16'hE03F, 1'b0);
    wr_h(10'h080, 16'hFFFF); expect_rd("R2 mvol", 10'h080, 16'hFF77, 1'b0);
    wr_h(10'h082, 16'hFFFF); expect_rd("R2 mix", 10'h082, 16'h770F, 1'b0);
    wr_h(10'h208, 16'hFFFF); expect_rd("R2 ime", 10'h208, 16'h0001, 1'b0);
  endtask

  task automatic t_dstat;
    vid_stat = 3'b101;
    wr_h(10'h004, 16'hFFFF); expect_rd("R3 dstat", 10'h004, 16'hFFFD, 1'b0);
    vid_stat = 3'b010;
    wr_h(10'h004, 16'h0007); expect_rd("R3 dstat low", 10'h004, 16'h0002, 1'b0);
  endtask

  task automatic t_sound_ctl;
    snd_act = 4'hA;
    wr_h(10'h084, 16'hFF0F);
    expect_rd("R4 sctl off", 10'h084, 16'h000A, 1'b0);
    chk("R4 snd_on off", {15'h0, snd_on}, 16'h0000);
    wr_h(10'h084, 16'h0080);
    expect_rd("R4 sctl on", 10'h084, 16'h008A, 1'b0);
    chk("R4 snd_on on", {15'h0, snd_on}, 16'h0001);
  endtask

  task automatic t_gate;
    wr_h(10'h084, 16'h0000);
    expect_rd("R5 ch1sw gated", 10'h060, 16'h0000, 1'b0);
    expect_rd("R5 mix gated", 10'h082, 16'h0000, 1'b0);
    expect_rd("R5 bias open", 10'h088, 16'h0200, 1'b0);
    wr_h(10'h084, 16'h0080);
    expect_rd("R5 ch1sw kept", 10'h060, 16'h007F, 1'b0);
  endtask

  task automatic t_irq;
    @(negedge clk); irq_raise = 16'h00FF;
    @(negedge clk); irq_raise = 16'h0000;
    expect_rd("R6 raised", 10'h202, 16'h00FF, 1'b0);
    wr_h(10'h202, 16'h00F0);
    expect_rd("R6 cleared", 10'h202, 16'h000F, 1'b0);
    @(negedge clk); addr = 10'h202; wdata = 16'h0003; bsel = 1'b0; wr = 1'b1;
    irq_raise = 16'h0001;
    @(negedge clk); wr = 1'b0; irq_raise = 16'h0000;
    expect_rd("R12 raise wins", 10'h202, 16'h000D, 1'b0);
  endtask

  task automatic t_bytes;
    wr_h(10'h000, 16'h1234);
    wr_b(10'h001, 8'hAB);
    expect_rd("R7 high lane", 10'h000, 16'hAB34, 1'b0);
    wr_b(10'h000, 8'h56);
    expect_rd("R7 low lane", 10'h000, 16'hAB56, 1'b0);
    chk("R7 view", disp_ctrl, 16'hAB56);
    @(negedge clk); irq_raise = 16'h0100;
    @(negedge clk); irq_raise = 16'h0000;
    wr_b(10'h202, 8'h01);
    expect_rd("R7 flag merge", 10'h202, 16'h000C, 1'b0);
  endtask

  task automatic t_writeonly;
    wr_h(10'h018, 16'h0222);
    chk("R8 pa view", wo_view[79:64], 16'h0222);
    expect_rd("R8 pa read", 10'h018, BAD, 1'b1);
    expect_rd("R8 dma read", 10'h0B2, BAD, 1'b1);
  endtask

  task automatic t_unmapped;
    expect_rd("R9 far", 10'h3F0, BAD, 1'b1);
    expect_rd("R9 timer low", 10'h100, BAD, 1'b1);
    expect_rd("R11 readable", 10'h000, 16'hAB56, 1'b0);
  endtask

  task automatic t_halt;
    wr_b(10'h301, 8'h00);
    chk("R10 halt", {14'h0, halt_req, stop_req}, 16'h0002);
    @(negedge clk);
    chk("R10 pulse", {14'h0, halt_req, stop_req}, 16'h0000);
    wr_b(10'h301, 8'h80);
    chk("R10 stop", {14'h0, halt_req, stop_req}, 16'h0001);
    wr_h(10'h300, 16'h8080);
    chk("R10 halfword", {14'h0, halt_req, stop_req}, 16'h0000);
  endtask

  task automatic t_latency;
    logic [15:0] d; logic e;
    @(negedge clk); addr = 10'h088; rd = 1'b1;
    @(posedge clk); #1;
    chk("R11 after edge", rdata, 16'h0200);
    @(negedge clk); rd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 hold", rdata, 16'h0200);
    wr_h(10'h088, 16'h1111);
    chk("R11 no read", rdata, 16'h0200);
    rd_h(10'h088, d, e);
    chk("R11 new", d, 16'h1111);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masks();
    t_dstat();
    t_sound_ctl();
    t_gate();
    t_irq();
    t_bytes();
    t_writeonly();
    t_unmapped();
    t_halt();
    t_latency();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule